// File: doc/BRIEF.md
# Double-Buffered SPI Transfer Engine

This block moves 8-bit words over a four-wire serial link, either as the clocking side (master) or as the clocked side (slave). A host writes a word with a one-cycle write strobe into a one-word transmit holding register. Whenever the shift register is free, the engine moves that word into it, frees the holding register again and starts shifting. Words that arrive from the line land in a one-word receive holding register. The host takes a word out of it with a read strobe. Two flags tell the host when the transmit register has room and when the receive register holds a word.

In master mode an external rate generator supplies `bit_tick` pulses. The engine waits one tick after loading a word, then makes one clock edge per tick, so a word takes sixteen edges. It drives the serial clock and data-out lines. In slave mode the clock, select and data-in lines are brought into the clock domain through two-stage synchronizers, and each synchronized clock transition is one edge. Clock polarity, clock phase and bit order are selected by static configuration inputs. A word queued while another is in flight starts as soon as the current one ends. A received word that finds the receive register still full is thrown away without notice.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset `tx_empty` is 1, `rx_full` is 0, and `mst_sck_o`, `mst_sdo_o` and `slv_sdo_o` are 0 (all configuration inputs at 0).
- R2: A write with `tx_empty`=1 drives `tx_empty` to 0 in the next cycle. In master mode with the shifter idle, the word moves into the shifter one cycle later and `tx_empty` returns to 1.
- R3: In master mode the first `bit_tick` after a load is a lead-in. Each further tick toggles `mst_sck_o`, and sixteen toggles (eight clock cycles) complete a word. During those toggles the written word goes out on `mst_sdo_o` and eight bits are taken from `mst_sdi_i`. At the end, the received word is placed in the receive register and `rx_full` becomes 1.
- R4: With `cfg_cpol`=0 the idle level of `mst_sck_o` is low, and with `cfg_cpol`=1 it is high. After the sixteenth toggle the clock is back at that level, and it rests there between words, including chained words.
- R5: With `cfg_cpha`=0, data is sampled on the leading edge (the edge leaving the idle level) and the output changes on the trailing edge, and the first bit is valid before the first edge. With `cfg_cpha`=1, the output changes on the leading edge and data is sampled on the trailing edge.
- R6: With `cfg_lsb_first`=0 bit 7 is sent and received first. With `cfg_lsb_first`=1 bit 0 comes first, in both directions.
- R7: A word written while a transfer is in progress waits in the transmit register. It is loaded and started as soon as the current word completes, without host action.
- R8: If a word completes while `rx_full`=1 and no read is made in that cycle, the new word is discarded. The receive register keeps the older word and no error indication exists.
- R9: `rd_data` always shows the receive register. An `rd_en` pulse clears `rx_full` in the next cycle.
- R10: A write while `tx_empty`=0 is ignored: the waiting word is not replaced and no extra transfer occurs.
- R11: In slave mode a word is exchanged while `slv_sel_n_i` is low, with the same phase, polarity and order rules. With `cfg_cpha`=1 the select may stay low across consecutive words.
- R12: In slave mode, raising `slv_sel_n_i` in the middle of a word abandons it. No word is received, the edge count restarts from zero, and the partly shifted word is not resumed.
- R13: `slv_sdo_o` is 0 while the slave is deselected or the engine is in master mode. Once the select is low and a word is loaded, `slv_sdo_o` presents the first bit before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = master mode, 0 = slave mode |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lsb_first | input | 1 | 1 = bit 0 first |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write word |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Receive register contents |
| tx_empty | output | 1 | Transmit register has room |
| rx_full | output | 1 | Receive register holds a word |
| bit_tick | input | 1 | Half-bit rate pulse for master mode |
| mst_sck_o | output | 1 | Master serial clock |
| mst_sdo_o | output | 1 | Master data out |
| mst_sdi_i | input | 1 | Master data in |
| slv_sck_i | input | 1 | Slave serial clock |
| slv_sel_n_i | input | 1 | Slave select, active low |
| slv_sdi_i | input | 1 | Slave data in |
| slv_sdo_o | output | 1 | Slave data out |

## Verification
The assertions check the buffer rules on every cycle. A load empties the transmit register, a write to a full transmit register leaves it unchanged, a completion into a full receive register leaves it unchanged, and a read clears the full flag. They also check that the master clock is at its idle level right after each word and that a deselected slave holds its edge count at zero. Only the bench scenarios can show that the right bits cross the line. That covers all four clock formats, both bit orders, chained words and the overrun drop. It also covers a slave word abandoned half way and the first bit presented before the first edge, all of which need a model of the far end.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef struct packed {
        logic master;
        logic cpol;
        logic cpha;
        logic lsb_first;
    } spi_cfg_t;

    // An edge samples input data when it is leading and phase is 0,
    // or when it is trailing and phase is 1.
    function automatic logic sample_edge(input logic cpha, input logic lead);
        return lead ^ cpha;
    endfunction

endpackage

// File: rtl/spi_host_bufs.sv
module spi_host_bufs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          take,
    input  logic          done,
    input  logic [DW-1:0] done_byte,
    output logic [DW-1:0] tx_data,
    output logic          tx_full,
    output logic [DW-1:0] rx_data,
    output logic          rx_full
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_data <= '0;
            tx_full <= 1'b0;
            rx_data <= '0;
            rx_full <= 1'b0;
        end else begin
            if (take) begin
                tx_full <= 1'b0;
            end else if (wr_en && !tx_full) begin
                tx_data <= wr_data;
                tx_full <= 1'b1;
            end

            if (done && (!rx_full || rd_en)) begin
                rx_data <= done_byte;
                rx_full <= 1'b1;
            end else if (rd_en) begin
                rx_full <= 1'b0;
            end
        end
    end

    a_r2_take_frees: assert property (@(posedge clk) disable iff (rst)
        take |=> !tx_full);

    a_r10_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (tx_full && wr_en) |=> (tx_data == $past(tx_data)));

    a_r8_overrun_keeps_old: assert property (@(posedge clk) disable iff (rst)
        (rx_full && done && !rd_en) |=> (rx_full && rx_data == $past(rx_data)));

    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !done) |=> !rx_full);

endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_i,
    input  logic sel_n_i,
    input  logic sdi_i,
    output logic sck_edge,
    output logic ss_act,
    output logic sdi_s
);

    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] sel_p;
    logic [STAGES-1:0] sdi_p;
    logic              sck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p    <= '0;
            sel_p    <= '1;
            sdi_p    <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_p    <= {sck_p[STAGES-2:0], sck_i};
            sel_p    <= {sel_p[STAGES-2:0], sel_n_i};
            sdi_p    <= {sdi_p[STAGES-2:0], sdi_i};
            sck_last <= sck_p[STAGES-1];
        end
    end

    always_comb begin
        sck_edge = sck_p[STAGES-1] ^ sck_last;
        ss_act   = ~sel_p[STAGES-1];
        sdi_s    = sdi_p[STAGES-1];
    end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_eng_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  spi_cfg_t      cfg,
    input  logic          bit_tick,
    input  logic          tx_full,
    input  logic [DW-1:0] tx_data,
    output logic          take,
    output logic          done,
    output logic [DW-1:0] done_byte,
    input  logic          mst_sdi,
    input  logic          sck_edge,
    input  logic          ss_act,
    input  logic          slv_sdi,
    output logic          sck_q,
    output logic          obit
);

    localparam int            EDGES = 2 * DW;
    localparam int            EW    = $clog2(EDGES);
    localparam logic [EW-1:0] LAST  = EW'(EDGES - 1);

    logic [DW-1:0] sr;
    logic          samp;
    logic [EW-1:0] e;
    logic          busy;
    logic          armed;
    logic          ev;
    logic          lead;
    logic          smp_now;
    logic          in_bit;

    function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] v,
                                               input logic b,
                                               input logic lsb);
        return lsb ? {b, v[DW-1:1]} : {v[DW-2:0], b};
    endfunction

    always_comb begin
        in_bit    = cfg.master ? mst_sdi : slv_sdi;
        ev        = cfg.master ? (bit_tick && busy && armed) : (sck_edge && ss_act);
        lead      = ~e[0];
        smp_now   = sample_edge(cfg.cpha, lead);
        take      = tx_full && !busy && (cfg.master || (e == '0 && !ev));
        done      = ev && (e == LAST);
        done_byte = shift_in(sr, cfg.cpha ? in_bit : samp, cfg.lsb_first);
        obit      = cfg.lsb_first ? sr[0] : sr[DW-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr    <= '0;
            samp  <= 1'b0;
            e     <= '0;
            busy  <= 1'b0;
            armed <= 1'b0;
            sck_q <= 1'b0;
        end else begin
            if (take) begin
                sr    <= tx_data;
                busy  <= 1'b1;
                armed <= 1'b0;
                e     <= '0;
            end else if (ev) begin
                e <= done ? '0 : e + 1'b1;
                if (done) begin
                    busy  <= 1'b0;
                    armed <= 1'b0;
                end
                if (smp_now) begin
                    samp <= in_bit;
                end else if (!(cfg.cpha && e == '0)) begin
                    sr <= shift_in(sr, samp, cfg.lsb_first);
                end
                if (cfg.master) begin
                    sck_q <= ~sck_q;
                end
            end else if (cfg.master && bit_tick && busy) begin
                armed <= 1'b1;
            end

            // deselect in slave mode drops a partial word
            if (!cfg.master && !ss_act && e != '0) begin
                e    <= '0;
                busy <= 1'b0;
            end

            if (cfg.master && !busy) begin
                sck_q <= cfg.cpol;
            end
        end
    end

    a_r4_sck_rests: assert property (@(posedge clk) disable iff (rst)
        (cfg.master && done) |=> (sck_q == $past(cfg.cpol)));

    a_r12_deselect_clears: assert property (@(posedge clk) disable iff (rst)
        (!cfg.master && !ss_act) |=> (e == '0));

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_master,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_empty,
    output logic              rx_full,
    input  logic              bit_tick,
    output logic              mst_sck_o,
    output logic              mst_sdo_o,
    input  logic              mst_sdi_i,
    input  logic              slv_sck_i,
    input  logic              slv_sel_n_i,
    input  logic              slv_sdi_i,
    output logic              slv_sdo_o
);

    spi_cfg_t          cfg;
    logic              take;
    logic              done;
    logic [DATA_W-1:0] done_byte;
    logic [DATA_W-1:0] tx_data;
    logic              tx_full;
    logic              sck_edge;
    logic              ss_act;
    logic              sdi_s;
    logic              sck_q;
    logic              obit;

    always_comb begin
        cfg.master    = cfg_master;
        cfg.cpol      = cfg_cpol;
        cfg.cpha      = cfg_cpha;
        cfg.lsb_first = cfg_lsb_first;
    end

    spi_host_bufs #(.DW(DATA_W)) u_bufs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .take     (take),
        .done     (done),
        .done_byte(done_byte),
        .tx_data  (tx_data),
        .tx_full  (tx_full),
        .rx_data  (rd_data),
        .rx_full  (rx_full)
    );

    spi_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .sck_i   (slv_sck_i),
        .sel_n_i (slv_sel_n_i),
        .sdi_i   (slv_sdi_i),
        .sck_edge(sck_edge),
        .ss_act  (ss_act),
        .sdi_s   (sdi_s)
    );

    spi_shift_core #(.DW(DATA_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .bit_tick (bit_tick),
        .tx_full  (tx_full),
        .tx_data  (tx_data),
        .take     (take),
        .done     (done),
        .done_byte(done_byte),
        .mst_sdi  (mst_sdi_i),
        .sck_edge (sck_edge),
        .ss_act   (ss_act),
        .slv_sdi  (sdi_s),
        .sck_q    (sck_q),
        .obit     (obit)
    );

    always_comb begin
        tx_empty  = ~tx_full;
        mst_sck_o = cfg_master ? sck_q : cfg_cpol;
        mst_sdo_o = cfg_master ? obit : 1'b0;
        slv_sdo_o = (!cfg_master && ss_act) ? obit : 1'b0;
    end

endmodule

// File: tb/test_spi_xfer_engine.sv
`timescale 1ns/1ps
module test_spi_xfer_engine;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_master, cfg_cpol, cfg_cpha, cfg_lsb_first;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       rd_en;
    logic [7:0] rd_data;
    logic       tx_empty, rx_full;
    logic       bit_tick;
    logic       mst_sck_o, mst_sdo_o, mst_sdi_i;
    logic       slv_sck_i, slv_sel_n_i, slv_sdi_i, slv_sdo_o;

    int n_chk = 0;
    int n_err = 0;
    logic cpha_r = 1'b0;
    logic lsb_r  = 1'b0;
    int tick_cnt = 0;

    always #2 clk = ~clk;

    spi_xfer_engine i_spi_xfer_engine (
        .clk(clk), .rst(rst),
        .cfg_master(cfg_master), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb_first(cfg_lsb_first),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .tx_empty(tx_empty), .rx_full(rx_full), .bit_tick(bit_tick),
        .mst_sck_o(mst_sck_o), .mst_sdo_o(mst_sdo_o), .mst_sdi_i(mst_sdi_i),
        .slv_sck_i(slv_sck_i), .slv_sel_n_i(slv_sel_n_i), .slv_sdi_i(slv_sdi_i),
        .slv_sdo_o(slv_sdo_o)
    );

    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
        bit_tick <= (tick_cnt == 3);
    end

    function automatic logic bitsel(input logic [7:0] b, input int i);
        return lsb_r ? b[i] : b[7-i];
    endfunction

    function automatic logic [7:0] shin(input logic [7:0] v, input logic b);
        return lsb_r ? {b, v[7:1]} : {v[6:0], b};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wait_cy(input int n);
        repeat (n) @(negedge clk);
    endtask

    // far-end slave model used while the engine is master
    logic       bm_en = 1'b0;
    logic       bm_prev = 1'b0;
    logic [7:0] bm_q0, bm_q1, bm_cur, bm_rxv, bm_got0, bm_got1;
    int         bm_k, bm_bi, bm_edges, bm_gi;

    task automatic bm_preset();
        if (!cpha_r) begin
            mst_sdi_i = bitsel(bm_cur, 0);
            bm_bi = 1;
        end else begin
            bm_bi = 0;
        end
    endtask

    always @(negedge clk) begin
        if (bm_en && mst_sck_o !== bm_prev) begin
            if ((bm_k % 2 == 0) ^ cpha_r) begin
                bm_rxv = shin(bm_rxv, mst_sdo_o);
            end else begin
                if (bm_bi < 8) mst_sdi_i = bitsel(bm_cur, bm_bi);
                bm_bi++;
            end
            bm_k++;
            bm_edges++;
            if (bm_k == 16) begin
                if (bm_gi == 0) bm_got0 = bm_rxv;
                else if (bm_gi == 1) bm_got1 = bm_rxv;
                bm_gi++;
                bm_k = 0;
                bm_cur = bm_q1;
                bm_preset();
            end
        end
        bm_prev = mst_sck_o;
    end

    task automatic bm_start(input logic [7:0] b0, input logic [7:0] b1);
        bm_q0 = b0; bm_q1 = b1; bm_cur = b0;
        bm_gi = 0; bm_k = 0; bm_edges = 0; bm_rxv = 8'h00;
        bm_got0 = 8'h00; bm_got1 = 8'h00;
        bm_preset();
        bm_en = 1'b1;
    endtask

    task automatic wait_gi(input int n);
        for (int i = 0; i < 1000 && bm_gi < n; i++) @(negedge clk);
    endtask

    task automatic set_cfg(input logic m, input logic cp, input logic ph, input logic lsb);
        @(negedge clk);
        bm_en = 1'b0;
        cfg_master = m; cfg_cpol = cp; cfg_cpha = ph; cfg_lsb_first = lsb;
        cpha_r = ph; lsb_r = lsb;
        slv_sck_i = cp;
        wait_cy(H);
    endtask

    task automatic host_wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_rd(output logic [7:0] v);
        @(negedge clk);
        v = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic slv_xfer(input logic [7:0] mo, input bit keep, output logic [7:0] mi);
        mi = 8'h00;
        if (slv_sel_n_i) begin
            slv_sel_n_i = 1'b0;
            wait_cy(H);
        end
        for (int i = 0; i < 8; i++) begin
            if (!cpha_r) begin
                slv_sdi_i = bitsel(mo, i);
                wait_cy(H);
                mi = shin(mi, slv_sdo_o);
                slv_sck_i = ~slv_sck_i;
                wait_cy(H);
                slv_sck_i = ~slv_sck_i;
            end else begin
                slv_sck_i = ~slv_sck_i;
                slv_sdi_i = bitsel(mo, i);
                wait_cy(H);
                mi = shin(mi, slv_sdo_o);
                slv_sck_i = ~slv_sck_i;
                wait_cy(H);
            end
        end
        wait_cy(H);
        if (!keep) begin
            slv_sel_n_i = 1'b1;
            wait_cy(H);
        end
    endtask

    // ---------------- scenarios ----------------

    task automatic t_reset();
        @(negedge clk);
        chk("R1 tx_empty after reset", tx_empty, 1);
        chk("R1 rx_full after reset", rx_full, 0);
        chk("R1 mst_sck_o after reset", mst_sck_o, 0);
        chk("R1 sdo lines after reset", {mst_sdo_o, slv_sdo_o}, 0);
    endtask

    task automatic t_write_timing();
        logic [7:0] v;
        set_cfg(1, 0, 0, 0);
        bm_start(8'h11, 8'h00);
        host_wr(8'h6D);
        chk("R2 tx_empty low after write", tx_empty, 0);
        wait_cy(1);
        chk("R2 tx_empty back after load", tx_empty, 1);
        wait_gi(1); wait_cy(2);
        chk("R2 loaded word sent", bm_got0, 8'h6D);
        host_rd(v);
    endtask

    task automatic t_master(input logic cp, input logic ph, input logic lsb,
                            input logic [7:0] d, input logic [7:0] b);
        logic [7:0] v;
        set_cfg(1, cp, ph, lsb);
        chk("R4 master sck idle level", mst_sck_o, cp);
        bm_start(b, 8'h00);
        host_wr(d);
        wait_gi(1); wait_cy(2);
        chk("R3 sixteen sck edges", bm_edges, 16);
        chk("R5 R6 word seen by far end", bm_got0, d);
        chk("R3 rx_full after word", rx_full, 1);
        chk("R5 R6 word received", rd_data, b);
        chk("R4 sck back at idle", mst_sck_o, cp);
        host_rd(v);
        chk("R9 rx_full cleared by read", rx_full, 0);
    endtask

    task automatic t_chain_overrun();
        logic [7:0] v;
        set_cfg(1, 0, 0, 0);
        bm_start(8'hA1, 8'h5E);
        host_wr(8'hC4);
        wait_cy(2);
        host_wr(8'h3B);
        host_wr(8'hFF);
        chk("R10 tx_empty stays low", tx_empty, 0);
        wait_gi(2);
        wait_cy(120);
        chk("R7 R10 only two words on line", bm_edges, 32);
        chk("R7 first word", bm_got0, 8'hC4);
        chk("R10 queued word not replaced", bm_got1, 8'h3B);
        chk("R8 rx_full held", rx_full, 1);
        chk("R8 older word kept", rd_data, 8'hA1);
        host_rd(v);
        chk("R9 read value", v, 8'hA1);
        chk("R9 rx_full cleared", rx_full, 0);
    endtask

    task automatic t_chain_read();
        logic [7:0] v;
        set_cfg(1, 1, 1, 0);
        bm_start(8'h29, 8'hD6);
        host_wr(8'h70);
        wait_cy(2);
        host_wr(8'h8E);
        wait_gi(1); wait_cy(2);
        host_rd(v);
        chk("R7 first received", v, 8'h29);
        wait_gi(2); wait_cy(2);
        chk("R7 second word sent", bm_got1, 8'h8E);
        chk("R7 second received", rd_data, 8'hD6);
        chk("R4 sck idle after chain", mst_sck_o, 1);
        host_rd(v);
    endtask

    task automatic t_slave(input logic cp, input logic ph, input logic lsb,
                           input logic [7:0] d, input logic [7:0] b);
        logic [7:0] mi, v;
        set_cfg(0, cp, ph, lsb);
        slv_sel_n_i = 1'b1;
        host_wr(d);
        wait_cy(2);
        slv_xfer(b, 0, mi);
        chk("R11 slave word sent", mi, d);
        chk("R11 slave rx_full", rx_full, 1);
        chk("R11 slave word received", rd_data, b);
        host_rd(v);
    endtask

    task automatic t_slave_keep();
        logic [7:0] mi, v;
        set_cfg(0, 0, 1, 0);
        host_wr(8'h12);
        wait_cy(2);
        slv_xfer(8'hED, 1, mi);
        chk("R11 keep-select first sent", mi, 8'h12);
        chk("R11 keep-select first rx", rd_data, 8'hED);
        host_rd(v);
        host_wr(8'h34);
        wait_cy(2);
        slv_xfer(8'hCB, 0, mi);
        chk("R11 keep-select second sent", mi, 8'h34);
        chk("R11 keep-select second rx", rd_data, 8'hCB);
        host_rd(v);
    endtask

    task automatic t_slave_abort();
        logic [7:0] mi, v;
        set_cfg(0, 0, 0, 0);
        chk("R13 sdo quiet when deselected", slv_sdo_o, 0);
        host_wr(8'hF0);
        wait_cy(2);
        slv_sel_n_i = 1'b0;
        wait_cy(H);
        chk("R13 first bit before first edge", slv_sdo_o, 1);
        slv_sdi_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            slv_sck_i = ~slv_sck_i;
            wait_cy(H);
        end
        slv_sel_n_i = 1'b1;
        wait_cy(H);
        chk("R13 sdo quiet after deselect", slv_sdo_o, 0);
        chk("R12 partial word not received", rx_full, 0);
        slv_sck_i = 1'b0;
        wait_cy(H);
        host_wr(8'h5A);
        wait_cy(2);
        slv_xfer(8'hC3, 0, mi);
        chk("R12 fresh word sent after abort", mi, 8'h5A);
        chk("R12 fresh word received", rd_data, 8'hC3);
        host_rd(v);
    endtask

    initial begin
        rst = 1'b1;
        cfg_master = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0;
        wr_en = 1'b0; wr_data = 8'h00; rd_en = 1'b0;
        mst_sdi_i = 1'b0;
        slv_sck_i = 1'b0; slv_sel_n_i = 1'b1; slv_sdi_i = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_timing();
        t_master(0, 0, 0, 8'hA5, 8'h3C);
        t_master(1, 0, 0, 8'h96, 8'h0F);
        t_master(0, 1, 0, 8'h4E, 8'hB1);
        t_master(1, 1, 1, 8'h81, 8'h7E);
        t_master(0, 0, 1, 8'h2C, 8'hD3);
        t_chain_overrun();
        t_chain_read();
        t_slave(0, 0, 0, 8'h96, 8'h4B);
        t_slave(1, 1, 1, 8'h81, 8'h7E);
        t_slave(1, 0, 0, 8'h3D, 8'hE2);
        t_slave_keep();
        t_slave_abort();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule